// File: doc/BRIEF.md
# Transmit Descriptor List Walker

This block steps an Ethernet transmit DMA through a chain of descriptors held in memory. Software writes a list base address, which also loads the walk pointer, and then raises a run bit. The walker reads the three words of the descriptor at the pointer through a single-outstanding memory port. Word 0 carries the flags, word 1 the buffer length in its upper 16 bits and word 2 the buffer address. If the descriptor is marked valid, the walker passes the buffer address and length to a transfer engine and waits until the engine reports done. It then writes word 0 back with the valid flag cleared.

After the writeback the pointer moves to the next descriptor, which sits 16 bytes further on. If the descriptor carried the list-end flag, the pointer returns to the base address instead. The walk goes on while the run bit stays set. When a fetched descriptor is not valid, the walker clears the run bit itself and halts. The pointer stays on that descriptor, so the next run resumes there.

The controller is a six-state machine. ST_IDLE goes to ST_RD_REQ on a start. ST_RD_REQ goes to ST_RD_RSP when the memory port accepts the read. ST_RD_RSP goes to ST_IDLE on an invalid word 0 (the halt transition), back to ST_RD_REQ for the next word, or to ST_XFER after word 2. ST_XFER goes to ST_WB_REQ on done. ST_WB_REQ goes to ST_WB_RSP when the write is accepted. ST_WB_RSP goes back to ST_RD_REQ if the run bit is still set, and to ST_IDLE otherwise.

Top module: `tx_desc_walker`

## Requirements
- R1: During and right after reset, status is 0 (idle), the run bit is 0 and neither mem_req_valid nor xfer_req is asserted.
- R2: A 0-to-1 change of the run bit while idle starts a fetch at the current pointer. A base write loads the pointer and on its own starts no memory access.
- R3: A fetch reads the byte addresses ptr, ptr+4 and ptr+8 in that order, one access at a time. Each request holds its address until it is accepted, and the next request waits for the response.
- R4: If bit 31 of word 0 is 0, the walker clears the run bit, returns to idle and issues neither a transfer nor a writeback for that descriptor.
- R5: The transfer request carries word 2 as the address and bits 31:16 of word 1 as the length. It stays asserted with stable values until xfer_done.
- R6: The writeback happens only after xfer_done. It writes word 0 to address ptr with bit 31 cleared and every other bit unchanged.
- R7: After a writeback the pointer becomes ptr+16 when bit 30 of word 0 is 0, and the base address when bit 30 is 1.
- R8: With the run bit still set after a writeback, the next descriptor is fetched. If software has cleared the run bit, the walker goes idle after that writeback and reads nothing further.
- R9: Status reads 1 while reading descriptor words, 2 while the transfer is requested and 3 during the writeback.
- R10: After a halt the pointer stays on the invalid descriptor, so a new run resumes at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_wr | input | 1 | Software write strobe for the run bit |
| run_wdata | input | 1 | Value written to the run bit |
| base_wr | input | 1 | Software write strobe for the list base (also loads the pointer) |
| base_wdata | input | ADDR_W | List base byte address |
| run_o | output | 1 | Current run bit |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address of the access |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Response for the accepted access (read data or write ack) |
| mem_rsp_rdata | input | DATA_W | Read data |
| xfer_req | output | 1 | Buffer transfer request |
| xfer_addr | output | ADDR_W | Buffer address |
| xfer_len | output | LEN_W | Buffer length |
| xfer_done | input | 1 | Transfer completed |
| status | output | 2 | 0 idle, 1 fetching, 2 transferring, 3 writing back |

## Verification
A straight chain that ends in an invalid descriptor shows the 16-byte step and the halt. Re-running after that descriptor has been made valid shows that the pointer was held on the descriptor that caused the halt. A two-entry ring whose second entry has the list-end flag runs against a stalling memory and a slow transfer engine. It separates the wrap to the base from the linear step, checks that the writeback keeps the list-end bit, and checks that requests hold under backpressure. A base write with no run, and a run bit cleared in the middle of a transfer, show that nothing is fetched without permission and that the walk stops after the current writeback.

// File: rtl/twd_pkg.sv
package twd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_REQ = 3'd1,
        ST_RD_RSP = 3'd2,
        ST_XFER   = 3'd3,
        ST_WB_REQ = 3'd4,
        ST_WB_RSP = 3'd5
    } walk_state_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_XFER  = 2'd2,
        PH_WB    = 2'd3
    } walk_phase_e;

endpackage

// File: rtl/twd_regs.sv
module twd_regs #(
    parameter int ADDR_W     = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_wr,
    input  logic              run_wdata,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              halt,
    input  logic              advance,
    input  logic              last_flag,
    input  logic              idle,
    output logic              run_o,
    output logic              start_o,
    output logic [ADDR_W-1:0] ptr_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

    logic              run_q;
    logic              run_d1;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] ptr_q;

    // run bit: a halt from the walker wins over a software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            run_d1 <= 1'b0;
        end else begin
            if (halt) begin
                run_q <= 1'b0;
            end else if (run_wr) begin
                run_q <= run_wdata;
            end
            run_d1 <= run_q;
        end
    end

    // base register and walk pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ptr_q  <= '0;
        end else begin
            if (base_wr) begin
                base_q <= base_wdata;
                ptr_q  <= base_wdata;
            end else if (advance) begin
                ptr_q <= last_flag ? base_q : ptr_q + STEP;
            end
        end
    end

    assign run_o   = run_q;
    assign start_o = run_q & ~run_d1 & idle;
    assign ptr_o   = ptr_q;

endmodule

// File: rtl/twd_desc_store.sv
module twd_desc_store #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int LEN_W       = 16,
    parameter int FETCH_WORDS = 3,
    parameter int IDX_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] word0,
    output logic [LEN_W-1:0]  buf_len,
    output logic [ADDR_W-1:0] buf_addr
);

    localparam logic [IDX_W-1:0] FLAG_WORD = IDX_W'(0);
    localparam logic [IDX_W-1:0] LEN_WORD  = IDX_W'(1);
    localparam logic [IDX_W-1:0] ADDR_WORD = IDX_W'(FETCH_WORDS - 1);

    logic [DATA_W-1:0] flags_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            len_q   <= '0;
            addr_q  <= '0;
        end else if (cap_en) begin
            if (cap_idx == FLAG_WORD) flags_q <= rdata;
            if (cap_idx == LEN_WORD)  len_q   <= rdata[DATA_W-1 -: LEN_W];
            if (cap_idx == ADDR_WORD) addr_q  <= rdata[ADDR_W-1:0];
        end
    end

    assign word0    = flags_q;
    assign buf_len  = len_q;
    assign buf_addr = addr_q;

endmodule

// File: rtl/twd_fsm.sv
module twd_fsm
    import twd_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int LEN_W       = 16,
    parameter int WORD_BYTES  = 4,
    parameter int FETCH_WORDS = 3,
    parameter int IDX_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [DATA_W-1:0] word0,
    input  logic [LEN_W-1:0]  buf_len,
    input  logic [ADDR_W-1:0] buf_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic              rsp_valid_bit,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    input  logic              xfer_done,
    output logic              cap_en,
    output logic [IDX_W-1:0]  cap_idx,
    output logic              halt,
    output logic              advance,
    output logic              idle,
    output logic [1:0]        status
);

    localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(FETCH_WORDS - 1);
    localparam logic [DATA_W-1:0] CLR_VALID  = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [ADDR_W-1:0] WORD_STEP  = ADDR_W'(WORD_BYTES);

    walk_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                idx_d = '0;
                if (start) state_d = ST_RD_REQ;
            end
            ST_RD_REQ: begin
                if (mem_req_ready) state_d = ST_RD_RSP;
            end
            ST_RD_RSP: begin
                if (mem_rsp_valid) begin
                    if (idx_q == '0 && !rsp_valid_bit) begin
                        state_d = ST_IDLE;
                        idx_d   = '0;
                    end else if (idx_q == LAST_IDX) begin
                        state_d = ST_XFER;
                        idx_d   = '0;
                    end else begin
                        state_d = ST_RD_REQ;
                        idx_d   = idx_q + 1'b1;
                    end
                end
            end
            ST_XFER: begin
                if (xfer_done) state_d = ST_WB_REQ;
            end
            ST_WB_REQ: begin
                if (mem_req_ready) state_d = ST_WB_RSP;
            end
            ST_WB_RSP: begin
                if (mem_rsp_valid) state_d = run ? ST_RD_REQ : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = ptr;
        mem_req_wdata = '0;
        xfer_req      = 1'b0;
        cap_en        = 1'b0;
        halt          = 1'b0;
        advance       = 1'b0;
        idle          = 1'b0;
        status        = PH_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                idle = 1'b1;
            end
            ST_RD_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = ptr + ADDR_W'(idx_q) * WORD_STEP;
                status        = PH_FETCH;
            end
            ST_RD_RSP: begin
                cap_en = mem_rsp_valid;
                halt   = mem_rsp_valid && (idx_q == '0) && !rsp_valid_bit;
                status = PH_FETCH;
            end
            ST_XFER: begin
                xfer_req = 1'b1;
                status   = PH_XFER;
            end
            ST_WB_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_wdata = word0 & CLR_VALID;
                status        = PH_WB;
            end
            ST_WB_RSP: begin
                advance = mem_rsp_valid;
                status  = PH_WB;
            end
            default: idle = 1'b1;
        endcase
    end

    assign cap_idx   = idx_q;
    assign xfer_addr = buf_addr;
    assign xfer_len  = buf_len;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    // R5
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=>
            (xfer_req && $stable(xfer_addr) && $stable(xfer_len)));

    // R6
    wb_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid && mem_req_write) |-> $past(xfer_done));

    // R6
    wb_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> !mem_req_wdata[DATA_W-1]);

endmodule

// File: rtl/tx_desc_walker.sv
module tx_desc_walker
    import twd_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int LEN_W       = 16,
    parameter int DESC_BYTES  = 16,
    parameter int FETCH_WORDS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_wr,
    input  logic              run_wdata,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic              run_o,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    input  logic              xfer_done,
    output logic [1:0]        status
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int IDX_W      = $clog2(FETCH_WORDS + 1);

    logic              start;
    logic              halt;
    logic              advance;
    logic              idle;
    logic              cap_en;
    logic [IDX_W-1:0]  cap_idx;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] word0;
    logic [LEN_W-1:0]  buf_len;
    logic [ADDR_W-1:0] buf_addr;

    twd_regs #(
        .ADDR_W     (ADDR_W),
        .DESC_BYTES (DESC_BYTES)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_wr     (run_wr),
        .run_wdata  (run_wdata),
        .base_wr    (base_wr),
        .base_wdata (base_wdata),
        .halt       (halt),
        .advance    (advance),
        .last_flag  (word0[DATA_W-2]),
        .idle       (idle),
        .run_o      (run_o),
        .start_o    (start),
        .ptr_o      (ptr)
    );

    twd_desc_store #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .LEN_W       (LEN_W),
        .FETCH_WORDS (FETCH_WORDS),
        .IDX_W       (IDX_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .rdata    (mem_rsp_rdata),
        .word0    (word0),
        .buf_len  (buf_len),
        .buf_addr (buf_addr)
    );

    twd_fsm #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .LEN_W       (LEN_W),
        .WORD_BYTES  (WORD_BYTES),
        .FETCH_WORDS (FETCH_WORDS),
        .IDX_W       (IDX_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .run           (run_o),
        .ptr           (ptr),
        .word0         (word0),
        .buf_len       (buf_len),
        .buf_addr      (buf_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .rsp_valid_bit (mem_rsp_rdata[DATA_W-1]),
        .xfer_req      (xfer_req),
        .xfer_addr     (xfer_addr),
        .xfer_len      (xfer_len),
        .xfer_done     (xfer_done),
        .cap_en        (cap_en),
        .cap_idx       (cap_idx),
        .halt          (halt),
        .advance       (advance),
        .idle          (idle),
        .status        (status)
    );

    // R4
    halt_stops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!run_o && status == PH_IDLE && !xfer_req));

    // R2
    start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (status == PH_FETCH && mem_req_valid && mem_req_addr == $past(ptr)));

endmodule

// File: tb/tx_desc_walker_bench.sv
`timescale 1ns/1ps
module tx_desc_walker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_wr = 1'b0, run_wdata = 1'b0, base_wr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        run_o;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        xfer_req;
    logic [31:0] xfer_addr;
    logic [15:0] xfer_len;
    logic        xfer_done = 1'b0;
    logic [1:0]  status;

    always #2.5 clk = ~clk;

    tx_desc_walker u_tx_desc_walker (
        .clk(clk), .rst_n(rst_n), .run_wr(run_wr), .run_wdata(run_wdata),
        .base_wr(base_wr), .base_wdata(base_wdata), .run_o(run_o),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .xfer_req(xfer_req), .xfer_addr(xfer_addr),
        .xfer_len(xfer_len), .xfer_done(xfer_done), .status(status)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // memory, reference image and expected event queues
    logic [31:0] mem [logic [31:0]];
    logic [31:0] rm  [logic [31:0]];
    logic [31:0] exp_rd[$], exp_xa[$], exp_wa[$], exp_wd[$];
    logic [15:0] exp_xl[$];
    logic [31:0] mptr = '0, base_m = '0;
    int          rdy_mode = 0, xfer_lat = 1, acc_cnt = 0, cyc_n = 0;
    bit          pend = 0, pend_wr = 0, done_given = 0, xf_busy = 0;
    logic [31:0] pend_data = '0;
    int          xf_cnt = 0;

    function automatic logic [31:0] rdmem(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // behavioural reference: walk the list on a private copy of memory
    task automatic predict(input int limit);
        logic [31:0] w0, w1;
        int n = 0;
        rm = mem;
        forever begin
            exp_rd.push_back(mptr);
            w0 = rm.exists(mptr) ? rm[mptr] : 32'h0;
            if (!w0[31]) break;
            w1 = rm[mptr + 32'd4];
            exp_rd.push_back(mptr + 32'd4);
            exp_rd.push_back(mptr + 32'd8);
            exp_xa.push_back(rm[mptr + 32'd8]);
            exp_xl.push_back(w1[31:16]);
            exp_wa.push_back(mptr);
            exp_wd.push_back(w0 & 32'h7fff_ffff);
            rm[mptr] = w0 & 32'h7fff_ffff;
            n++;
            mptr = w0[30] ? base_m : mptr + 32'd16;
            if (n == limit) break;
        end
    endtask

    // memory and transfer-engine models, compared every clock
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid = 1'b0; xfer_done = 1'b0; pend = 0; xf_busy = 0;
        end else begin
            cyc_n++;
            mem_rsp_valid = 1'b0;
            xfer_done     = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = pend_data;
                pend = 0;
            end
            mem_req_ready = (rdy_mode == 0) ? 1'b1 : ((cyc_n % 3) != 0);
            if (mem_req_valid) begin
                if (mem_req_write) chk(status == 2'd3, "R9 wb status", status, 3);
                else               chk(status == 2'd1, "R9 fetch status", status, 1);
            end
            if (mem_req_valid && mem_req_ready) begin
                acc_cnt++;
                pend = 1; pend_wr = mem_req_write;
                if (mem_req_write) begin
                    chk(done_given, "R6 writeback before done", 0, 1);
                    done_given = 0;
                    if (exp_wa.size() == 0) chk(0, "R8 unexpected write", mem_req_addr, 0);
                    else begin
                        logic [31:0] ea, ed;
                        ea = exp_wa.pop_front(); ed = exp_wd.pop_front();
                        chk(mem_req_addr == ea, "R6 wb addr", mem_req_addr, ea);
                        chk(mem_req_wdata == ed, "R6 wb data", mem_req_wdata, ed);
                    end
                    mem[mem_req_addr] = mem_req_wdata;
                    pend_data = 32'h0;
                end else begin
                    if (exp_rd.size() == 0) chk(0, "R8 unexpected read", mem_req_addr, 0);
                    else begin
                        logic [31:0] er;
                        er = exp_rd.pop_front();
                        chk(mem_req_addr == er, "R3 R7 read addr", mem_req_addr, er);
                    end
                    pend_data = rdmem(mem_req_addr);
                end
            end
            if (xfer_req) chk(status == 2'd2, "R9 xfer status", status, 2);
            if (xf_busy) begin
                chk(xfer_req, "R5 request dropped", xfer_req, 1);
                if (xf_cnt == 0) begin
                    xfer_done = 1'b1; xf_busy = 0; done_given = 1;
                end else xf_cnt--;
            end else if (xfer_req) begin
                if (exp_xa.size() == 0) chk(0, "R4 unexpected transfer", xfer_addr, 0);
                else begin
                    logic [31:0] xa; logic [15:0] xl;
                    xa = exp_xa.pop_front(); xl = exp_xl.pop_front();
                    chk(xfer_addr == xa, "R5 xfer addr", xfer_addr, xa);
                    chk(xfer_len == xl, "R5 xfer len", xfer_len, xl);
                end
                xf_busy = 1; xf_cnt = xfer_lat;
            end
        end
    end

    task automatic set_desc(input logic [31:0] a, input bit v, input bit last,
                            input logic [15:0] len, input logic [31:0] buf_a);
        mem[a]         = {v, last, 22'h0, 8'h5a};
        mem[a + 32'd4] = {len, 16'h1234};
        mem[a + 32'd8] = buf_a;
    endtask

    task automatic sw_base(input logic [31:0] a);
        @(negedge clk); base_wr = 1'b1; base_wdata = a;
        @(negedge clk); base_wr = 1'b0;
        mptr = a; base_m = a;
    endtask

    task automatic sw_run(input bit v);
        @(negedge clk); run_wr = 1'b1; run_wdata = v;
        @(negedge clk); run_wr = 1'b0;
    endtask

    task automatic wait_done();
        repeat (4) @(negedge clk);
        while (!(status == 2'd0 && run_o == 1'b0)) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic end_checks(input string tag);
        chk(exp_rd.size() == 0, {tag, " reads left"}, exp_rd.size(), 0);
        chk(exp_xa.size() == 0, {tag, " transfers left"}, exp_xa.size(), 0);
        chk(exp_wa.size() == 0, {tag, " writes left"}, exp_wa.size(), 0);
        chk(status == 2'd0, {tag, " idle"}, status, 0);
        chk(run_o == 1'b0, {tag, " run bit"}, run_o, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", cyc_n, 0);
        finish_run();
    end

    initial begin
        int acc0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(status == 2'd0, "R1 status", status, 0);
        chk(run_o == 1'b0, "R1 run", run_o, 0);
        chk(!mem_req_valid && !xfer_req, "R1 requests", {mem_req_valid, xfer_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 2'd0 && !mem_req_valid, "R1 after reset", status, 0);

        // linear chain, halt on fourth descriptor (R3 R4 R7)
        set_desc(32'h1000, 1, 0, 16'h0040, 32'h8000);
        set_desc(32'h1010, 1, 0, 16'h0041, 32'h8100);
        set_desc(32'h1020, 1, 0, 16'h0042, 32'h8200);
        set_desc(32'h1030, 0, 0, 16'h0043, 32'h8300);
        sw_base(32'h1000);
        predict(1000);
        sw_run(1);
        wait_done();
        end_checks("R4 linear");
        chk(mem[32'h1000][31] == 1'b0, "R6 cleared valid", mem[32'h1000], 32'h5a);

        // resume at halted descriptor (R10 R2)
        set_desc(32'h1030, 1, 0, 16'h0043, 32'h8300);
        set_desc(32'h1040, 0, 0, 16'h0044, 32'h8400);
        predict(1000);
        chk(exp_rd[0] == 32'h1030, "R10 model resume", exp_rd[0], 32'h1030);
        sw_run(1);
        wait_done();
        end_checks("R10 resume");

        // ring with list-end, stalling memory, slow engine (R7 R3 R5)
        rdy_mode = 1; xfer_lat = 4;
        set_desc(32'h2000, 1, 0, 16'h0100, 32'h9000);
        set_desc(32'h2010, 1, 1, 16'h0200, 32'h9100);
        sw_base(32'h2000);
        predict(1000);
        sw_run(1);
        wait_done();
        end_checks("R7 ring");
        chk(mem[32'h2010] == 32'h4000_005a, "R6 keeps other bits", mem[32'h2010], 32'h4000_005a);

        // base write alone starts nothing (R2)
        rdy_mode = 0; xfer_lat = 5;
        set_desc(32'h3000, 1, 0, 16'h0010, 32'ha000);
        set_desc(32'h3010, 1, 0, 16'h0011, 32'ha100);
        set_desc(32'h3020, 1, 1, 16'h0012, 32'ha200);
        acc0 = acc_cnt;
        sw_base(32'h3000);
        repeat (10) @(negedge clk);
        chk(acc_cnt == acc0, "R2 no access on base write", acc_cnt, acc0);
        chk(status == 2'd0, "R2 idle after base write", status, 0);

        // run cleared during transfer: stop after writeback (R8)
        predict(1);
        sw_run(1);
        while (status != 2'd2) @(negedge clk);
        run_wr = 1'b1; run_wdata = 1'b0;
        @(negedge clk); run_wr = 1'b0;
        wait_done();
        end_checks("R8 stop");
        chk(mem[32'h3010][31] == 1'b1, "R8 next untouched", mem[32'h3010], 32'h8000_005a);

        finish_run();
    end

endmodule